// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Block Read Host

This block is the host side of a read from a three-wire serial EEPROM. A one-cycle start request carries a start address and a word count. The block then selects the device and runs the serial clock from a divided system clock. It sends a start bit, the read opcode and the address, and collects the returned serial stream into parallel words. Each word is presented with a one-cycle strobe.

After the last address bit is clocked in, the device puts a single zero bit on its output before the first data word. The host samples returned data on the falling serial clock edge. It counts that zero as the final sample of the command phase and throws it away, so every captured word starts exactly on its most significant bit. As long as select stays high, the device keeps sending words from successive addresses, and the host keeps clocking until the requested count has arrived.

Top module: `mw_rd_host`

## Requirements
- R1: A start request while idle with a nonzero word count makes `busy_o` and `cs_o` high from the next cycle. A start request with a word count of zero is ignored.
- R2: The host drives a command of ADDR_W+3 bits on `sdo_o`, one bit per serial clock period: 1, then 1, then 0, then the address MSB first. `sdo_o` changes only together with a falling serial clock edge, so it is stable at each rising edge.
- R3: `sclk_o` is low while idle. Its first rising edge comes DIV system cycles after the start is accepted, and it then toggles every DIV cycles, giving a period of 2*DIV cycles.
- R4: `sdi_i` is sampled in the cycle in which `sclk_o` falls.
- R5: The sample taken on the falling edge of the final address bit's period is the device's leading zero and is discarded. The first captured bit is taken one period later.
- R6: Words are WORD_W bits, MSB first. Word m (counted from 1) appears on `word_o` with a one-cycle `valid_o` pulse 2*DIV*(ADDR_W+3+m*WORD_W) cycles after the start is accepted.
- R7: Successive words are captured back to back with no gap bits. They hold the contents of consecutive device addresses, wrapping at the top of the address space.
- R8: After the last requested word, `cs_o` and `busy_o` drop and `sclk_o` is low. `done_o` pulses for one cycle, in the same cycle as the last `valid_o`.
- R9: A start request while busy is ignored: the running transfer keeps its timing and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| addr_i | input | ADDR_W | Start address |
| nwords_i | input | CNT_W | Number of words to read |
| cs_o | output | 1 | Device select |
| sclk_o | output | 1 | Serial clock to device |
| sdo_o | output | 1 | Serial command data to device |
| sdi_i | input | 1 | Serial data from device |
| word_o | output | WORD_W | Last captured word |
| valid_o | output | 1 | Word strobe, one cycle |
| done_o | output | 1 | Transfer complete, one cycle |
| busy_o | output | 1 | Transfer in progress |

## Verification
Two events can fall in the same cycle: the capture of the final word and the end of the transfer. The `valid_o` strobe and the `done_o` pulse share one falling serial clock edge, and `cs_o` drops in that same cycle. The bench runs transfers of one, several and wrapping word counts, and a behavioural model predicts, cycle by cycle, when the strobe, the done pulse and the select release occur. A start request placed during a transfer, and another placed in the first idle cycle after done, show whether the end of one transfer and the acceptance of the next are kept apart.

// File: rtl/mw_rd_pkg.sv
package mw_rd_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} mw_state_e;
  localparam int unsigned CMD_HDR_W = 3;
  localparam logic [CMD_HDR_W-1:0] CMD_HDR = 3'b110; // start bit, then read opcode
endpackage

// File: rtl/mw_clk_div.sv
module mw_clk_div #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/mw_cmd_ser.sv
module mw_cmd_ser
  import mw_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  output logic              bit_o
);
  localparam int unsigned CMD_LEN = ADDR_W + CMD_HDR_W;

  logic [CMD_LEN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= {CMD_HDR, addr_i};
    else if (adv_i)  sr_q <= {sr_q[CMD_LEN-2:0], 1'b0};
  end

  assign bit_o = sr_q[CMD_LEN-1];
endmodule

// File: rtl/mw_deser.sv
module mw_deser #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] next_o
);
  logic [WORD_W-1:0] sr_q;

  assign next_o = {sr_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= next_o;
  end
endmodule

// File: rtl/mw_rd_host.sv
module mw_rd_host
  import mw_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DIV    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  nwords_i,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int unsigned CMD_LEN = ADDR_W + CMD_HDR_W;
  localparam int unsigned PW      = $clog2(CMD_LEN + 1);
  localparam int unsigned BW      = $clog2(WORD_W);
  localparam logic [PW-1:0] PH_LAST  = PW'(CMD_LEN);
  localparam logic [BW-1:0] BIT_LAST = BW'(WORD_W - 1);

  mw_state_e         state_q;
  logic              cs_q, sclk_q, valid_q, done_q;
  logic [PW-1:0]     ph_q;
  logic [BW-1:0]     bit_q;
  logic [CNT_W-1:0]  left_q;
  logic [WORD_W-1:0] word_q, next_word;
  logic              tick, fall, capture, start_ok;

  assign start_ok = (state_q == ST_IDLE) && start_i && (nwords_i != '0);
  assign fall     = tick && sclk_q;
  // samples up to and including the final address bit period are dropped
  assign capture  = fall && (ph_q == PH_LAST);

  mw_clk_div #(.DIV(DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_RUN),
    .tick_o (tick)
  );

  mw_cmd_ser #(.ADDR_W(ADDR_W)) u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_ok),
    .addr_i (addr_i),
    .adv_i  (fall),
    .bit_o  (sdo_o)
  );

  mw_deser #(.WORD_W(WORD_W)) u_des (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (capture),
    .bit_i   (sdi_i),
    .next_o  (next_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b0;
      sclk_q  <= 1'b0;
      ph_q    <= '0;
      bit_q   <= '0;
      left_q  <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          state_q <= ST_RUN;
          cs_q    <= 1'b1;
          sclk_q  <= 1'b0;
          ph_q    <= '0;
          bit_q   <= '0;
          left_q  <= nwords_i;
        end
        ST_RUN: begin
          if (tick) sclk_q <= !sclk_q;
          if (fall && !capture) ph_q <= ph_q + 1'b1;
          if (capture) begin
            if (bit_q == BIT_LAST) begin
              bit_q   <= '0;
              word_q  <= next_word;
              valid_q <= 1'b1;
              left_q  <= left_q - 1'b1;
              if (left_q == CNT_W'(1)) begin
                state_q <= ST_IDLE;
                cs_q    <= 1'b0;
                done_q  <= 1'b1;
              end
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_o    = cs_q;
  assign sclk_o  = sclk_q;
  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign done_o  = done_q;
  assign busy_o  = (state_q == ST_RUN);
endmodule

// File: rtl/mw_rd_host_chk.sv
module mw_rd_host_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cs_o,
  input logic sclk_o,
  input logic sdo_o,
  input logic valid_o,
  input logic done_o,
  input logic busy_o
);
  // R3
  idle_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sclk_o);
  // R2
  sdo_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(sdo_o));
  // R8
  done_on_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> (done_o && valid_o));
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !cs_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind mw_rd_host mw_rd_host_chk u_chk (.*);

// File: tb/tb_mw_rd_host.sv
module tb_mw_rd_host;
  localparam int ADDR_W  = 6;
  localparam int WORD_W  = 16;
  localparam int CNT_W   = 8;
  localparam int DIV     = 2;
  localparam int CLK_T   = 10;
  localparam int CMD_LEN = ADDR_W + 3;
  localparam int DEPTH   = 1 << ADDR_W;

  logic clk = 0, rst_n = 0, start = 0, dev_do = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [CNT_W-1:0] nw = '0;
  logic cs, sclk, sdo, valid, done, busy;
  logic [WORD_W-1:0] word;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_T/2) clk = ~clk;

  mw_rd_host #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W), .DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .nwords_i(nw),
    .cs_o(cs), .sclk_o(sclk), .sdo_o(sdo), .sdi_i(dev_do),
    .word_o(word), .valid_o(valid), .done_o(done), .busy_o(busy));

  function automatic logic [WORD_W-1:0] word_at(int i);
    logic [31:0] t;
    t = (i * 4957) ^ 32'h0000c3a5 ^ (i << 9);
    return t[WORD_W-1:0];
  endfunction

  task automatic fail(string req, string what, int act, int exp);
    n_bad++;
    $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
  endtask

  // device model: shifts command in on rising sclk, answers zero then words
  int rc = 0, dev_a = 0, dev_bp = 0;
  logic [CMD_LEN-1:0] dev_cmd = '0;
  always @(posedge sclk or negedge cs) begin
    if (!cs) begin
      rc = 0;
      dev_do <= 1'b1;
    end else begin
      rc = rc + 1;
      if (rc <= CMD_LEN) dev_cmd = {dev_cmd[CMD_LEN-2:0], sdo};
      if (rc == CMD_LEN) begin
        n_cmp++;
        if (dev_cmd[CMD_LEN-1 -: 3] != 3'b110) fail("R2", "cmd header", int'(dev_cmd[CMD_LEN-1 -: 3]), 6);
        dev_a = int'(dev_cmd[ADDR_W-1:0]);
        dev_bp = 0;
        dev_do <= 1'b0;
      end else if (rc > CMD_LEN) begin
        dev_do <= word_at(dev_a)[WORD_W-1-dev_bp];
        dev_bp = dev_bp + 1;
        if (dev_bp == WORD_W) begin
          dev_bp = 0;
          dev_a = (dev_a + 1) % DEPTH;
        end
      end
    end
  end

  // behavioural reference: cycles since accepted start
  bit m_act = 0;
  int k = 0, T = 0;
  logic [WORD_W-1:0] exp_q[$];
  logic [WORD_W-1:0] exp_w;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0;
    end else begin
      if (m_act) begin
        k++;
        if (k > T) m_act = 0;
      end
      if (!m_act && start && nw != 0) begin
        m_act = 1;
        k = 0;
        T = 2 * DIV * (CMD_LEN + int'(nw) * WORD_W);
        for (int m = 0; m < int'(nw); m++) exp_q.push_back(word_at((int'(addr) + m) % DEPTH));
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic e_busy, e_done, e_sclk, e_valid;
      e_busy  = m_act && k < T;
      e_done  = m_act && k == T;
      e_sclk  = e_busy && ((k / DIV) % 2 == 1);
      e_valid = m_act && k > 2*DIV*CMD_LEN && ((k - 2*DIV*CMD_LEN) % (2*DIV*WORD_W) == 0);
      n_cmp++;
      if (busy !== e_busy) fail("R1/R9", "busy_o", busy, e_busy);
      if (cs !== e_busy) fail("R1/R8", "cs_o", cs, e_busy);
      if (sclk !== e_sclk) fail("R3", "sclk_o", sclk, e_sclk);
      if (done !== e_done) fail("R8", "done_o", done, e_done);
      if (valid !== e_valid) fail("R6", "valid_o", valid, e_valid);
      if (valid && e_valid) begin
        n_cmp++;
        if (exp_q.size() == 0) fail("R7", "extra word", int'(word), 0);
        else begin
          exp_w = exp_q.pop_front();
          // R4 R5 R6 R7: alignment and content of each word
          if (word !== exp_w) fail("R4/R5/R7", "word_o", int'(word), int'(exp_w));
        end
      end
    end
  end

  task automatic go(int a, int n);
    @(negedge clk);
    start = 1; addr = ADDR_W'(a); nw = CNT_W'(n);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_act) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if ({cs, sclk, sdo, valid, done, busy} !== 6'b0) fail("R1/R3", "reset outputs", int'({cs, sclk, sdo, valid, done, busy}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    go(0, 1);  wait_idle();                      // R6 single word
    go(10, 4); wait_idle();                      // R7 back to back
    go(62, 3); wait_idle();                      // R7 address wrap
    go(5, 0);  repeat (20) @(negedge clk);       // R1 zero count ignored
    n_cmp++;
    if (busy !== 1'b0) fail("R1", "zero count busy", busy, 0);
    go(33, 2);                                   // R9 start while busy
    repeat (40) @(negedge clk);
    start = 1; addr = 6'd7; nw = 8'd5;
    @(negedge clk); start = 0;
    wait_idle();
    go(21, 2);                                   // R8 restart right after done
    @(negedge clk);
    while (!done) @(negedge clk);
    start = 1; addr = 6'd40; nw = 8'd1;
    @(negedge clk); start = 0;
    wait_idle();
    n_cmp++;
    if (exp_q.size() != 0) fail("R7", "words missing", exp_q.size(), 0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fail("ALL", "watchdog", 0, 1);
    summary();
  end
endmodule